// File: doc/BRIEF.md
# Throttled Serial Word Receiver

This block takes compressed data from a host that sends it in bursts over two wires: a bit clock and a data line. Each bit is taken on a rising edge of the host's bit clock, most significant bit first. There is no framing or word-select line. A bit counter alone marks the word boundaries: every sixteenth bit closes a word, and that word is written into a small internal FIFO. A consumer drains the FIFO through a valid/ready stream port. The consumer applies back-pressure by holding `out_ready` low. While `out_valid` is high and `out_ready` is low, the head word stays on `out_data` unchanged. A word leaves the FIFO only on a cycle where both signals are high.

The host is throttled by `req_n`, an active-low request output that follows FIFO occupancy with hysteresis. `req_n` goes high once free space drops below `stop_free`, which leaves room for words the host already has in flight. It goes low again only once free space rises above `go_free`. A word that completes while the FIFO is full is discarded, and a sticky overflow flag records this until the consumer side clears it.

The host bit clock is oversampled in the `clk` domain. It must therefore stay high and low for at least three `clk` periods each.

Top module: `bursty_rx`

## Requirements
- R1: After reset, `req_n` is 0, `out_valid` is 0, `fill` is 0, `ovf` is 0 and the bit counter is at zero.
- R2: `bit_dat` is taken on each rising edge of `bit_clk`, and the first bit of a word becomes bit 15 of that word (MSB first).
- R3: Words come out of `out_data` in the order they arrived. Only a cycle with `out_valid` and `out_ready` both high removes the head word. While `out_valid` is high and `out_ready` is low, `out_data` holds.
- R4: `fill` equals the number of words held, from 0 to DEPTH, and `out_valid` is high exactly when `fill` is nonzero.
- R5: When `req_n` is 0 and free space (DEPTH - `fill`) is below `stop_free`, `req_n` goes to 1 on the next cycle. `req_n` never rises otherwise.
- R6: When `req_n` is 1, it returns to 0 only on the cycle after free space exceeds `go_free`. For free space between the two thresholds it keeps its value.
- R7: A word that completes while `fill` equals DEPTH is discarded. The stored words and `fill` stay unchanged, and `ovf` becomes 1.
- R8: `ovf` stays 1 until `ovf_clr` is sampled high. A drop on that same cycle wins, and `ovf` stays 1.
- R9: Word boundaries come only from counting bits. A partial word is never delivered, and a pause in `bit_clk` keeps the partial word, which continues with the next bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk | input | 1 | Host bit clock, asynchronous to `clk` |
| bit_dat | input | 1 | Host serial data, taken on rising `bit_clk` |
| req_n | output | 1 | Active-low request: 0 means the host may send |
| stop_free | input | CNT_W (4) | Free-space level below which `req_n` rises |
| go_free | input | CNT_W (4) | Free-space level above which `req_n` falls |
| out_valid | output | 1 | FIFO holds a word |
| out_ready | input | 1 | Consumer accepts the head word |
| out_data | output | WORD_W (16) | Head word of the FIFO |
| fill | output | CNT_W (4) | Number of stored words |
| ovf | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clears `ovf` |

## Verification
A bit counter that slips by even one position rotates every later word. The first wrong `out_data` therefore appears at the first read after the slip, and nothing ever corrects it. An occupancy count that drifts from the pointers shows up at the ports as a `fill` that differs from the number of words written minus the number read. It also shows up as `req_n` switching at the wrong level within one cycle of the change. A bad full test shows up either as a lost word or as an `ovf` that is missing when a ninth word is sent to a full FIFO.

// File: rtl/bursty_rx_pkg.sv
package bursty_rx_pkg;
  // Throttle state; the encoding is the value driven on req_n.
  typedef enum logic {
    THR_OPEN = 1'b0,
    THR_HELD = 1'b1
  } thr_e;
endpackage

// File: rtl/bursty_rx_sampler.sv
module bursty_rx_sampler #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_clk,
  input  logic bit_dat,
  output logic bit_stb,
  output logic bit_val
);
  logic [SYNC_N-1:0] clk_sy;
  logic [SYNC_N-1:0] dat_sy;
  logic              clk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sy   <= '0;
      dat_sy   <= '0;
      clk_prev <= 1'b0;
    end else begin
      clk_sy   <= {clk_sy[SYNC_N-2:0], bit_clk};
      dat_sy   <= {dat_sy[SYNC_N-2:0], bit_dat};
      clk_prev <= clk_sy[SYNC_N-1];
    end
  end

  assign bit_stb = clk_sy[SYNC_N-1] & ~clk_prev;
  assign bit_val = dat_sy[SYNC_N-1];
endmodule

// File: rtl/bursty_rx_packer.sv
module bursty_rx_packer #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              bit_val,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data
);
  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [WORD_W-1:0] shreg;
  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] nxt;

  assign nxt = {shreg[WORD_W-2:0], bit_val};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      cnt     <= '0;
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (bit_stb) begin
        shreg <= nxt;
        if (cnt == LAST) begin
          cnt     <= '0;
          wr_en   <= 1'b1;
          wr_data <= nxt;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bursty_rx_fifo.sv
module bursty_rx_fifo #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              empty,
  output logic [CNT_W-1:0]  count,
  output logic              drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0]    LAST_A = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic              full, do_wr, do_rd;

  assign full  = (count == FULL_C);
  assign empty = (count == '0);
  assign do_wr = wr_en & ~full;
  assign do_rd = rd_en & ~empty;
  assign drop  = wr_en & full;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_wr) wp <= (wp == LAST_A) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == LAST_A) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/bursty_rx_throttle.sv
module bursty_rx_throttle
  import bursty_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] stop_free,
  input  logic [CNT_W-1:0] go_free,
  output logic             req_n
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  thr_e             st;
  logic [CNT_W-1:0] free;

  assign free  = DEPTH_C - count;
  assign req_n = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= THR_OPEN;
    end else begin
      unique case (st)
        THR_OPEN: if (free < stop_free) st <= THR_HELD;
        THR_HELD: if (free > go_free)   st <= THR_OPEN;
        default:  st <= THR_OPEN;
      endcase
    end
  end
endmodule

// File: rtl/bursty_rx.sv
module bursty_rx #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8,
  parameter int SYNC_N = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_clk,
  input  logic              bit_dat,
  output logic              req_n,
  input  logic [CNT_W-1:0]  stop_free,
  input  logic [CNT_W-1:0]  go_free,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic [CNT_W-1:0]  fill,
  output logic              ovf,
  input  logic              ovf_clr
);
  logic              bit_stb, bit_val;
  logic              wr_en, drop, empty;
  logic [WORD_W-1:0] wr_data;

  bursty_rx_sampler #(.SYNC_N(SYNC_N)) u_smp (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .bit_dat(bit_dat),
    .bit_stb(bit_stb), .bit_val(bit_val)
  );

  bursty_rx_packer #(.WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
    .wr_en(wr_en), .wr_data(wr_data)
  );

  bursty_rx_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(out_ready), .rd_data(out_data), .empty(empty),
    .count(fill), .drop(drop)
  );

  bursty_rx_throttle #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .count(fill), .stop_free(stop_free),
    .go_free(go_free), .req_n(req_n)
  );

  assign out_valid = ~empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf <= 1'b0;
    else if (drop)    ovf <= 1'b1;
    else if (ovf_clr) ovf <= 1'b0;
  end
endmodule

// File: rtl/bursty_rx_chk.sv
module bursty_rx_chk #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_n,
  input logic [CNT_W-1:0]  stop_free,
  input logic [CNT_W-1:0]  go_free,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic [CNT_W-1:0]  fill,
  input logic              ovf,
  input logic              ovf_clr
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  // R4: occupancy never exceeds the depth
  a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= DEPTH_C);

  // R3: held head word is stable under back-pressure
  a_r3_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5: req_n only rises after free space fell below stop level
  a_r5_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_n) |-> ((DEPTH_C - $past(fill)) < $past(stop_free)));

  // R6: req_n only falls after free space exceeded go level
  a_r6_go: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_n) |-> ((DEPTH_C - $past(fill)) > $past(go_free)));

  // R8: overflow flag is sticky until cleared
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);

  // R7: a rising overflow flag leaves the occupancy at full
  a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> (($past(fill) == DEPTH_C) || ($past(fill) == DEPTH_C - 1'b1)));
endmodule

bind bursty_rx bursty_rx_chk #(.WORD_W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_n(req_n), .stop_free(stop_free),
  .go_free(go_free), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .fill(fill), .ovf(ovf), .ovf_clr(ovf_clr)
);

// File: tb/bursty_rx_test.sv
module bursty_rx_test;
  localparam int DEPTH = 8;
  localparam int CW    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_clk = 1'b0, bit_dat = 1'b0;
  logic          req_n;
  logic [CW-1:0] stop_free = 4'd2, go_free = 4'd5;
  logic          out_valid, out_ready = 1'b0;
  logic [15:0]   out_data;
  logic [CW-1:0] fill;
  logic          ovf, ovf_clr = 1'b0;

  int total = 0, bad = 0;
  logic [15:0] q[$];
  logic m_req = 1'b0;
  logic m_ovf = 1'b0;

  always #4 clk = ~clk;

  bursty_rx uut (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .bit_dat(bit_dat),
    .req_n(req_n), .stop_free(stop_free), .go_free(go_free),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .fill(fill), .ovf(ovf), .ovf_clr(ovf_clr)
  );

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic thr_step(logic r, int cnt);
    int fr = DEPTH - cnt;
    if (!r && fr < int'(stop_free)) return 1'b1;
    if (r && fr > int'(go_free)) return 1'b0;
    return r;
  endfunction

  task automatic send_bit(logic b);
    bit_dat = b;
    tick(3);
    bit_clk = 1'b1;
    tick(3);
    bit_clk = 1'b0;
  endtask

  task automatic send_word(logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
    tick(8);
    if (q.size() < DEPTH) q.push_back(w);
    else m_ovf = 1'b1;
    m_req = thr_step(m_req, q.size());
  endtask

  task automatic pop_word(string tag);
    chk({tag, " valid"}, out_valid, 1'b1);
    chk({tag, " data"}, out_data, q[0]);
    out_ready = 1'b1;
    tick();
    out_ready = 1'b0;
    void'(q.pop_front());
    tick(2);
    m_req = thr_step(m_req, q.size());
  endtask

  task automatic check_state(string tag);
    chk({tag, " R4 fill"}, fill, q.size());
    chk({tag, " R4 valid"}, out_valid, q.size() != 0);
    chk({tag, " R5/R6 req_n"}, req_n, m_req);
    chk({tag, " R7/R8 ovf"}, ovf, m_ovf);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    tick(3);
    // R1 reset state
    chk("R1 req_n", req_n, 1'b0);
    chk("R1 out_valid", out_valid, 1'b0);
    chk("R1 fill", fill, 0);
    chk("R1 ovf", ovf, 1'b0);
    rst_n = 1'b1;
    tick(2);

    // R2 MSB-first assembly, distinct patterns
    send_word(16'h8001);
    check_state("R2 first");
    chk("R2 word", out_data, 16'h8001);
    send_word(16'h5AC3);
    // R3 back-pressure: head held while ready low
    tick(5);
    chk("R3 hold", out_data, 16'h8001);
    pop_word("R3 a");
    pop_word("R3 b");
    check_state("R3 empty");

    // R9 partial word survives a pause
    for (int i = 15; i >= 6; i--) send_bit(1'(16'hC3A5 >> i));
    tick(40);
    chk("R9 no partial", fill, 0);
    for (int i = 5; i >= 0; i--) send_bit(1'(16'hC3A5 >> i));
    tick(8);
    q.push_back(16'hC3A5);
    m_req = thr_step(m_req, q.size());
    check_state("R9 resume");
    chk("R9 word", out_data, 16'hC3A5);

    // R5/R6/R7 fill to full, then overflow
    for (int k = 0; k < DEPTH; k++) begin
      send_word(16'(k * 16'h1111 + 16'h0F0F));
      check_state("R5 fill");
    end
    chk("R7 ovf set", ovf, 1'b1);
    chk("R5 held", req_n, 1'b1);
    // R6 drain through hysteresis band
    while (q.size() > 0) begin
      pop_word("R6 drain");
      check_state("R6 drain");
    end

    // R8 clear
    ovf_clr = 1'b1;
    tick();
    ovf_clr = 1'b0;
    m_ovf = 1'b0;
    tick();
    chk("R8 ovf cleared", ovf, 1'b0);

    // Random mix of sends and pops
    for (int it = 0; it < 60; it++) begin
      if (($urandom % 2) == 0 || q.size() == 0) send_word(16'($urandom));
      else pop_word("R3 rnd");
      check_state("rnd");
      if (($urandom % 8) == 0) begin
        ovf_clr = 1'b1;
        tick();
        ovf_clr = 1'b0;
        m_ovf = 1'b0;
        tick();
        chk("R8 rnd clr", ovf, 1'b0);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule